// File: doc/BRIEF.md
# Adaptive Integration Mode Controller

This block sits behind the column readout of an image array whose pixels each hold a single mode bit selecting between a long exposure (a full frame) and a short exposure (a fixed fraction of the frame). For every digitized pixel sample, the block receives the 8-bit value together with the mode bit read from that pixel. It decides which mode the pixel should use in the next frame and writes that bit back. Each sample also produces one write strobe and one reset request for the pixel.

The mode decision has hysteresis. A pixel on long exposure moves to short exposure only when its value exceeds an upper threshold. A pixel on short exposure moves back only when its value falls under a lower threshold. The wide gap between the two thresholds stops noise from toggling a pixel between modes. The same sample is also turned into one linear wide-range word: short-exposure samples are scaled up by the exposure ratio (4, 16 or 64), so values from both exposures lie on a common 14-bit scale.

Both thresholds are programmable. A new pair is taken only when the upper threshold is strictly larger than the lower threshold times the selected ratio. All outputs are registered, one pixel clock after the sample.

Top module: `adaptive_exposure_ctrl`

## Requirements
- R1: After the synchronous active-high reset, wb_bit, wb_strobe, rst_strobe and wide_out are all 0, the upper threshold is 240 and the lower threshold is 10.
- R2: A valid sample with in_mode=0 (long exposure) and in_pix strictly greater than the upper threshold gives wb_bit=1 one clock later.
- R3: A valid sample with in_mode=1 (short exposure) and in_pix strictly less than the lower threshold gives wb_bit=0 one clock later.
- R4: In every other valid case, wb_bit one clock later equals in_mode. This includes a value exactly equal to either threshold.
- R5: wb_strobe and rst_strobe are both 1 in the clock after a cycle with in_valid=1, and both are 0 in the clock after a cycle with in_valid=0.
- R6: For a valid sample with in_mode=0, wide_out one clock later is in_pix zero-extended to 14 bits.
- R7: For a valid sample with in_mode=1, wide_out one clock later is in_pix shifted left by 2, 4 or 6 bits for ratio_sel 0, 1 or 2. ratio_sel=3 uses a shift of 6.
- R8: When cfg_we=1, the pair cfg_hi/cfg_lo replaces the thresholds from the next clock on, but only if cfg_hi > cfg_lo × ratio, with the ratio taken from ratio_sel in that cycle. Otherwise the write is ignored and the old thresholds stay. A sample in the same cycle as the write uses the old thresholds.
- R9: In the clock after a cycle with in_valid=0, wb_bit and wide_out keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_pix | input | 8 | Digitized pixel value |
| in_mode | input | 1 | Mode bit read from the pixel (0 long, 1 short) |
| ratio_sel | input | 2 | Exposure ratio: 0→4, 1→16, 2 or 3→64 |
| cfg_we | input | 1 | Threshold write request |
| cfg_hi | input | 8 | Proposed upper threshold |
| cfg_lo | input | 8 | Proposed lower threshold |
| wb_bit | output | 1 | Mode bit to write back |
| wb_strobe | output | 1 | Write-back strobe |
| rst_strobe | output | 1 | Pixel reset request |
| wide_out | output | 14 | Wide-range linear value |

## Verification
The bench drives values exactly at 240 and 10 and at one step on each side. A design that compares with ≥ or ≤ would switch modes at the threshold itself. Each ratio_sel code, including the spare code 3, is applied to short-exposure samples, so a wrong shift table shows up as a scaled wide_out. Threshold writes that break the ratio gap are followed by samples that would switch only under the rejected pair, which exposes a missing guard. Gaps in in_valid expose strobes that linger, and a mode bit or wide word that changes without a sample.

// File: rtl/aec_pkg.sv
package aec_pkg;
  localparam int PIX_W   = 8;
  localparam int SEL_W   = 2;
  localparam int MAX_SH  = 6;
  localparam int WIDE_W  = PIX_W + MAX_SH;
  localparam logic [PIX_W-1:0] HI_RST = 8'd240;
  localparam logic [PIX_W-1:0] LO_RST = 8'd10;

  typedef enum logic {EXP_LONG = 1'b0, EXP_SHORT = 1'b1} exp_mode_t;

  function automatic int unsigned shift_of(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/aec_thresholds.sv
module aec_thresholds
  import aec_pkg::*;
#(
  parameter int W = PIX_W,
  parameter logic [W-1:0] HI_INIT = HI_RST,
  parameter logic [W-1:0] LO_INIT = LO_RST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [W-1:0]     hi_new,
  input  logic [W-1:0]     lo_new,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     hi_q,
  output logic [W-1:0]     lo_q
);
  localparam int XW = W + MAX_SH;

  logic [XW-1:0] lo_scaled;
  logic [XW-1:0] hi_ext;
  logic          gap_ok;

  always_comb begin
    hi_ext    = XW'(hi_new);
    lo_scaled = XW'(lo_new) << shift_of(sel);
    gap_ok    = hi_ext > lo_scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= HI_INIT;
      lo_q <= LO_INIT;
    end else if (we && gap_ok) begin
      hi_q <= hi_new;
      lo_q <= lo_new;
    end
  end
endmodule

// File: rtl/aec_decide.sv
module aec_decide
  import aec_pkg::*;
#(
  parameter int W = PIX_W
) (
  input  logic [W-1:0] pix,
  input  exp_mode_t    cur,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output exp_mode_t    nxt
);
  logic too_bright;
  logic too_dark;

  always_comb begin
    too_bright = pix > hi;
    too_dark   = pix < lo;
    nxt        = cur;
    if (cur == EXP_LONG && too_bright)
      nxt = EXP_SHORT;
    else if (cur == EXP_SHORT && too_dark)
      nxt = EXP_LONG;
  end
endmodule

// File: rtl/aec_expand.sv
module aec_expand
  import aec_pkg::*;
#(
  parameter int W  = PIX_W,
  parameter int OW = W + MAX_SH
) (
  input  logic [W-1:0]     pix,
  input  exp_mode_t        cur,
  input  logic [SEL_W-1:0] sel,
  output logic [OW-1:0]    wide
);
  logic [OW-1:0] ext;
  logic [OW-1:0] scaled [4];

  assign ext = OW'(pix);

  for (genvar g = 0; g < 4; g++) begin : g_shift
    assign scaled[g] = ext << shift_of(SEL_W'(g));
  end

  always_comb begin
    if (cur == EXP_SHORT)
      wide = scaled[sel];
    else
      wide = ext;
  end
endmodule

// File: rtl/adaptive_exposure_ctrl.sv
module adaptive_exposure_ctrl
  import aec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_mode,
  input  logic [SEL_W-1:0]  ratio_sel,
  input  logic              cfg_we,
  input  logic [PIX_W-1:0]  cfg_hi,
  input  logic [PIX_W-1:0]  cfg_lo,
  output logic              wb_bit,
  output logic              wb_strobe,
  output logic              rst_strobe,
  output logic [WIDE_W-1:0] wide_out
);
  logic [PIX_W-1:0]  thr_hi;
  logic [PIX_W-1:0]  thr_lo;
  exp_mode_t         cur_mode;
  exp_mode_t         nxt_mode;
  logic [WIDE_W-1:0] wide_d;

  assign cur_mode = exp_mode_t'(in_mode);

  aec_thresholds #(.W(PIX_W)) u_thr (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .hi_new (cfg_hi),
    .lo_new (cfg_lo),
    .sel    (ratio_sel),
    .hi_q   (thr_hi),
    .lo_q   (thr_lo)
  );

  aec_decide #(.W(PIX_W)) u_dec (
    .pix (in_pix),
    .cur (cur_mode),
    .hi  (thr_hi),
    .lo  (thr_lo),
    .nxt (nxt_mode)
  );

  aec_expand #(.W(PIX_W), .OW(WIDE_W)) u_exp (
    .pix  (in_pix),
    .cur  (cur_mode),
    .sel  (ratio_sel),
    .wide (wide_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_bit     <= 1'b0;
      wb_strobe  <= 1'b0;
      rst_strobe <= 1'b0;
      wide_out   <= '0;
    end else begin
      wb_strobe  <= in_valid;
      rst_strobe <= in_valid;
      if (in_valid) begin
        wb_bit   <= nxt_mode;
        wide_out <= wide_d;
      end
    end
  end
endmodule

// File: rtl/aec_checker.sv
module aec_checker
  import aec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [PIX_W-1:0]  in_pix,
  input logic              in_mode,
  input logic [SEL_W-1:0]  ratio_sel,
  input logic [PIX_W-1:0]  thr_hi,
  input logic [PIX_W-1:0]  thr_lo,
  input logic              wb_bit,
  input logic              wb_strobe,
  input logic              rst_strobe,
  input logic [WIDE_W-1:0] wide_out
);
  assert_to_short_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mode && in_pix > thr_hi) |=> wb_bit);

  assert_to_long_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode && in_pix < thr_lo) |=> !wb_bit);

  assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(!in_mode && in_pix > thr_hi) && !(in_mode && in_pix < thr_lo))
      |=> (wb_bit == $past(in_mode)));

  assert_strobe_on_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (wb_strobe && rst_strobe));

  assert_strobe_off_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wb_strobe && !rst_strobe));

  assert_wide_long_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mode) |=> (wide_out == WIDE_W'($past(in_pix))));

  assert_wide_x4_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode && ratio_sel == 2'd0) |=> (wide_out == {4'b0, $past(in_pix), 2'b0}));

  assert_wide_x16_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode && ratio_sel == 2'd1) |=> (wide_out == {2'b0, $past(in_pix), 4'b0}));

  assert_wide_x64_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode && ratio_sel[1]) |=> (wide_out == {$past(in_pix), 6'b0}));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(wb_bit) && $stable(wide_out)));
endmodule

bind adaptive_exposure_ctrl aec_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_pix     (in_pix),
  .in_mode    (in_mode),
  .ratio_sel  (ratio_sel),
  .thr_hi     (thr_hi),
  .thr_lo     (thr_lo),
  .wb_bit     (wb_bit),
  .wb_strobe  (wb_strobe),
  .rst_strobe (rst_strobe),
  .wide_out   (wide_out)
);

// File: tb/tb_adaptive_exposure_ctrl.sv
module tb_adaptive_exposure_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        in_mode = 1'b0;
  logic [1:0]  ratio_sel = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_hi = '0;
  logic [7:0]  cfg_lo = '0;
  logic        wb_bit, wb_strobe, rst_strobe;
  logic [13:0] wide_out;

  always #2.5 clk = ~clk;

  adaptive_exposure_ctrl dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int m_hi = 240;
  int m_lo = 10;
  int e_bit = 0;
  int e_stb = 0;
  int e_wide = 0;
  string t_bit = "R1";
  string t_wide = "R1";
  string t_stb = "R1";
  bit done = 0;

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    cmp(t_bit, int'(wb_bit), e_bit);
    cmp(t_stb, int'(wb_strobe), e_stb);
    cmp(t_stb, int'(rst_strobe), e_stb);
    cmp(t_wide, int'(wide_out), e_wide);
  endtask

  // Drive one cycle at a negedge, update the model, then compare at the next negedge.
  task automatic cyc(input bit v, input int pix, input bit mode, input int sel,
                     input bit we = 0, input int hi = 0, input int lo = 0);
    int sh;
    in_valid = v; in_pix = 8'(pix); in_mode = mode; ratio_sel = 2'(sel);
    cfg_we = we; cfg_hi = 8'(hi); cfg_lo = 8'(lo);
    sh = (sel == 0) ? 2 : (sel == 1) ? 4 : 6;
    e_stb = v;
    t_stb = "R5";
    if (v) begin
      if (!mode && pix > m_hi) begin e_bit = 1; t_bit = "R2"; end
      else if (mode && pix < m_lo) begin e_bit = 0; t_bit = "R3"; end
      else begin e_bit = mode; t_bit = "R4"; end
      if (mode) begin e_wide = pix << sh; t_wide = "R7"; end
      else begin e_wide = pix; t_wide = "R6"; end
    end else begin
      t_bit = "R9"; t_wide = "R9";
    end
    if (we && hi > (lo << sh)) begin m_hi = hi; m_lo = lo; end
    @(negedge clk);
    check_outputs();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p;
    int m;
    int s;
    repeat (3) @(negedge clk);
    // R1: reset values at the outputs
    cmp("R1", int'(wb_bit), 0);
    cmp("R1", int'(wb_strobe), 0);
    cmp("R1", int'(rst_strobe), 0);
    cmp("R1", int'(wide_out), 0);
    rst = 1'b0;
    // R1/R2/R4: default thresholds 240 and 10, boundaries
    cyc(1, 241, 0, 1);
    cyc(1, 240, 0, 1);
    cyc(1, 9,   1, 1);
    cyc(1, 10,  1, 1);
    cyc(1, 11,  1, 1);
    cyc(1, 255, 1, 1);
    cyc(1, 0,   0, 1);
    // R9/R5: gaps
    cyc(1, 200, 1, 0);
    cyc(0, 0,   0, 2);
    cyc(0, 77,  1, 3);
    // R7: every ratio code
    for (int k = 0; k < 4; k++) cyc(1, 255, 1, k);
    for (int k = 0; k < 4; k++) cyc(1, 3, 0, k);
    // R8: rejected write (20*16=320 >= 200), then probe
    cyc(0, 0, 0, 1, 1, 200, 20);
    cyc(1, 239, 0, 1);
    cyc(1, 19, 1, 1);
    // R8: write with same-cycle sample using old thresholds, accepted (20*4=80 < 200)
    cyc(1, 230, 0, 0, 1, 200, 20);
    cyc(1, 201, 0, 0);
    cyc(1, 200, 0, 0);
    cyc(1, 19, 1, 0);
    cyc(1, 20, 1, 0);
    // R8: equal product rejected (50*4 = 200)
    cyc(0, 0, 0, 0, 1, 200, 50);
    cyc(1, 30, 1, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      p = $urandom_range(0, 255);
      m = $urandom_range(0, 1);
      s = $urandom_range(0, 3);
      if ($urandom_range(0, 49) == 0)
        cyc($urandom_range(0, 3) != 0, p, m[0], s, 1,
            $urandom_range(100, 255), $urandom_range(0, 40));
      else
        cyc($urandom_range(0, 3) != 0, p, m[0], s);
    end
    // R1: reset again restores defaults
    rst = 1'b1;
    in_valid = 1'b0;
    cfg_we = 1'b0;
    @(negedge clk);
    cmp("R1", int'(wb_strobe), 0);
    cmp("R1", int'(wide_out), 0);
    rst = 1'b0;
    m_hi = 240; m_lo = 10; e_bit = 0; e_wide = 0;
    cyc(1, 241, 0, 1);
    cyc(1, 9, 1, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule